// File: doc/BRIEF.md
# Sampled Input Glitch Qualifier

This block sits between a noisy asynchronous digital pin and an edge-capture unit, for example a zero-crossing comparator output inside a switching power stage. The pin first crosses into the system clock domain through a two-flop synchronizer. In qualify mode, the synchronized level is then sampled on a slower strobe. The output moves to a new level only when six consecutive samples agree on that level.

The strobe is spaced by twice an 8-bit period value, counted in system clocks. The shortest pulse that can pass therefore scales with that setting, up to 510 clocks between samples at the largest value. In synchronize-only mode the filter is bypassed. The output then follows the pin two clocks later, with no rejection of short pulses.

Top module: `pin_qualifier`

## Requirements
- R1: While reset is asserted and just after it is released, `pin_out` is low and the sample history is cleared. After release, a pin that is held high reaches the output only after six high samples, even if it was high during reset.
- R2: The raw pin passes through exactly two flip-flops. With `qual_en` = 0 (synchronize only), `pin_out` equals the value `pin_raw` had two clock edges earlier.
- R3: In synchronize-only mode no sample-count filtering applies. A pin pulse one clock wide appears on `pin_out` one clock wide, two clocks late.
- R4: With `qual_en` = 1 (qualify), `pin_out` changes only on a sample strobe. It changes only when that sample and the five samples before it all show the new level.
- R5: Samples are taken every 2×`period` system clocks. A `period` of 0 takes a sample on every clock.
- R6: With `period` = 0 in qualify mode, a lasting level change at the pin reaches `pin_out` exactly 8 clocks later: 2 clocks of synchronizer and 6 samples.
- R7: A sample that differs from the previous sample restarts the match count, so agreeing samples separated by a differing one do not add up.
- R8: In qualify mode, a pulse of either polarity that covers at most five sample strobes never reaches `pin_out`. A pulse that covers six strobes does reach it.
- R9: A `period` of 0xFF spaces samples 510 clocks apart. A change then reaches the output no earlier than 5×510+3 and no later than 6×510+2 clocks after the pin changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous, possibly noisy pin level |
| qual_en | input | 1 | 1 = sample-count qualification, 0 = synchronize only |
| period | input | 8 | Half the number of clocks between samples (0 = every clock) |
| pin_out | output | 1 | Cleaned level toward the capture logic |

## Verification
The bench drives pulses that cover exactly five and exactly six samples, of both polarities. A filter that counted five matches would let the first through, and one that needed seven would block the second. Split runs of four agreeing samples, separated by a single differing one, are aimed at a match counter that fails to restart; such a counter would wrongly flip the output. With the period at zero the output latency is checked to the exact cycle, so an extra or missing synchronizer stage shows up as a one-clock shift. At 0xFF the output must not move before the earliest possible sixth strobe and must have moved by the latest one, so a design that samples every `period` clocks instead of every 2×`period` clocks falls outside the window.

// File: rtl/pin_qualifier.sv
module pin_qualifier #(
  parameter int PERIOD_W    = 8,
  parameter int SAMPLES     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pin_raw,
  input  logic                qual_en,
  input  logic [PERIOD_W-1:0] period,
  output logic                pin_out
);

  localparam int CNT_W   = PERIOD_W + 1;
  localparam int MATCH_W = $clog2(SAMPLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-1:0]       limit;
  logic                   strobe;
  logic [MATCH_W-1:0]     match_cnt;
  logic                   last_s;
  logic                   qual_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};

  assign pin_s  = sync_q[SYNC_STAGES-1];
  assign limit  = {period, 1'b0} - CNT_W'(1);
  assign strobe = (period == '0) || (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt <= '0;
    else if (strobe) cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      last_s    <= 1'b0;
      match_cnt <= '0;
    end else if (strobe) begin
      if (pin_s != last_s) begin
        last_s    <= pin_s;
        match_cnt <= MATCH_W'(1);
      end else if (match_cnt < MATCH_W'(SAMPLES)) begin
        match_cnt <= match_cnt + MATCH_W'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      qual_q <= 1'b0;
    else if (strobe && pin_s == last_s && match_cnt == MATCH_W'(SAMPLES - 1))
      qual_q <= pin_s;

  assign pin_out = qual_en ? qual_q : pin_s;

endmodule

// File: rtl/pin_qualifier_chk.sv
module pin_qualifier_chk #(
  parameter int PERIOD_W = 8,
  parameter int SAMPLES  = 6,
  parameter int MATCH_W  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pin_raw,
  input logic                qual_en,
  input logic [PERIOD_W-1:0] period,
  input logic                pin_out,
  input logic                pin_s,
  input logic                strobe,
  input logic [MATCH_W-1:0]  match_cnt
);

  logic [1:0] live;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         live <= '0;
    else if (live != 2'd3) live <= live + 2'd1;

  // R1
  always @(posedge clk)
    if (!rst_n) reset_low_chk: assert (pin_out == 1'b0);

  // R2
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live >= 2'd2 && !qual_en) |-> pin_out == $past(pin_raw, 2));

  // R4
  qual_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live >= 2'd1 && qual_en && $past(qual_en) && pin_out != $past(pin_out))
      |-> ($past(strobe) && $past(match_cnt) == MATCH_W'(SAMPLES - 1) && pin_out == $past(pin_s)));

  // R7
  match_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_cnt <= MATCH_W'(SAMPLES));

  // R5
  every_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |-> strobe);

  // R5
  spaced_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live >= 2'd1 && period != '0 && $past(period) == period) |-> !(strobe && $past(strobe)));

endmodule

bind pin_qualifier pin_qualifier_chk #(
  .PERIOD_W(PERIOD_W), .SAMPLES(SAMPLES), .MATCH_W(MATCH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .qual_en(qual_en), .period(period),
  .pin_out(pin_out), .pin_s(pin_s), .strobe(strobe), .match_cnt(match_cnt)
);

// File: tb/pin_qualifier_tb.sv
`timescale 1ns/1ps
module pin_qualifier_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_raw = 1'b1;
  logic       qual_en = 1'b1;
  logic [7:0] period = 8'd0;
  logic       pin_out;

  int  cyc = 0;
  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  typedef struct { int at; bit val; string tag; } exp_t;
  exp_t sb[$];

  pin_qualifier u_dut (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw),
    .qual_en(qual_en), .period(period), .pin_out(pin_out)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int dly, bit v, string tag);
    exp_t e;
    e.at = cyc + dly; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        checks++;
        if (pin_out !== sb[i].val) begin
          failures++;
          $display("FAIL %s: cycle %0d pin_out=%0b expected %0b", sb[i].tag, cyc, pin_out, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: cycle %0d, expected completion", cyc);
    summary();
  end

  initial begin
    tick(3);
    checks++;
    if (pin_out !== 1'b0) begin
      failures++;
      $display("FAIL R1: pin_out=%0b expected 0 in reset", pin_out);
    end
    rst_n = 1'b1;
    // R1 / R6: pin high since reset, period 0
    expect_at(1, 1'b0, "R1");
    expect_at(7, 1'b0, "R1");
    expect_at(8, 1'b1, "R6");
    tick(15);

    // R8: low glitch covering five samples is rejected
    pin_raw = 1'b0;
    for (int k = 3; k <= 15; k += 3) expect_at(k, 1'b1, "R8");
    tick(5);
    pin_raw = 1'b1;
    tick(15);

    // R8 / R4: low pulse covering six samples passes
    pin_raw = 1'b0;
    expect_at(7, 1'b1, "R4");
    expect_at(8, 1'b0, "R8");
    expect_at(13, 1'b0, "R4");
    expect_at(14, 1'b1, "R4");
    tick(6);
    pin_raw = 1'b1;
    tick(20);

    // R7: runs of four lows split by one high never add up
    for (int k = 2; k <= 18; k += 2) expect_at(k, 1'b1, "R7");
    pin_raw = 1'b0; tick(4);
    pin_raw = 1'b1; tick(1);
    pin_raw = 1'b0; tick(4);
    pin_raw = 1'b1; tick(20);

    pin_raw = 1'b0;
    tick(20);
    expect_at(1, 1'b0, "R4");
    tick(3);

    // R2 / R3: synchronize-only mode
    qual_en = 1'b0;
    tick(3);
    pin_raw = 1'b1;
    expect_at(1, 1'b0, "R2");
    expect_at(2, 1'b1, "R3");
    expect_at(3, 1'b0, "R3");
    tick(1);
    pin_raw = 1'b0;
    tick(6);
    pin_raw = 1'b1;
    expect_at(1, 1'b0, "R2");
    expect_at(2, 1'b1, "R2");
    tick(5);
    pin_raw = 1'b0;
    tick(10);
    qual_en = 1'b1;
    tick(2);
    expect_at(1, 1'b0, "R3");
    tick(20);

    // R5: period 3, six clocks between samples
    period = 8'd3;
    tick(4);
    pin_raw = 1'b1;
    expect_at(32, 1'b0, "R5");
    expect_at(38, 1'b1, "R5");
    tick(50);
    pin_raw = 1'b0;
    for (int k = 1; k <= 10; k++) expect_at(k * 6, 1'b1, "R8");
    tick(30);
    pin_raw = 1'b1;
    tick(70);

    // R9: period 0xFF, 510 clocks between samples
    period = 8'hFF;
    pin_raw = 1'b0;
    tick(2);
    expect_at(5 * 510 + 2, 1'b1, "R9");
    expect_at(6 * 510 + 2, 1'b0, "R9");
    tick(3100);
    pin_raw = 1'b1;
    for (int k = 1; k <= 10; k++) expect_at(k * 510, 1'b0, "R8");
    tick(5 * 510);
    pin_raw = 1'b0;
    tick(5200);

    wait (sb.size() == 0);
    tick(2);
    summary();
  end

endmodule